// File: doc/BRIEF.md
# Configuration frame error checker

This block watches a serial configuration stream that arrives one bit per accepted transfer and checks three properties of it. It finds frame boundaries: between frames, runs of 1 act as stop bits and the first 0 opens a frame of `FRAME_LEN` bits. It requires at least three 1 bits directly ahead of every start bit. When parity is enabled, it checks two interleaved even-parity groups across each frame. When a frame carries the identification address, it compares the device code in that frame with a built-in constant. The same frame also carries the flag that turns parity checking on or off.

The first error of any kind stops the checker. It latches a per-type status vector and pulls `init_n` low. From then on it accepts and discards input bits until the reset input or the program request clears it. The bit input is a valid/ready stream that never applies back-pressure: `in_ready` is always 1, so a bit is consumed on every clock edge where `in_valid` is high. In the error state and during a program request, those consumed bits have no effect. `FRAME_LEN` must be at least `ID_ADDR_W + CODE_W + 3`.

Top module: `cfg_frame_checker`

## Requirements
- R1: After reset or a program request, `init_n` is 1, `err_status` is 000, parity checking is off, and the record of the last three bits holds zeros.
- R2: Outside a frame, an accepted 1 is a stop bit and the first accepted 0 is the start bit (position 0). A frame is exactly `FRAME_LEN` accepted bits at positions 0 to `FRAME_LEN-1`, and after the last one the checker is between frames again.
- R3: If any of the three bits accepted just before a start bit was 0, the checker sets `err_status[0]` (alignment). Because the record is cleared by R1, a stream must begin with at least three 1s.
- R4: When parity is on, the checker sets `err_status[1]` at the last bit of a frame if the bits at even positions (0, 2, ...) contain an odd number of ones. It does the same if the bits at odd positions (1, 3, ...) contain an odd number of ones.
- R5: Parity is off after R1. An ID frame loads its flag bit into the parity enable, and the new value governs frames from the next one on. The ID frame itself is judged with the old value.
- R6: A frame is an ID frame when positions 1 to `ID_ADDR_W` (first bit = MSB) equal `ID_ADDR`. Positions after that hold a `CODE_W`-bit code (MSB first), followed by the parity flag. If the code differs from `DEV_CODE`, the checker sets `err_status[2]` at the frame's last bit.
- R7: In a frame that is not an ID frame, the bits in the code and flag positions are never compared and do not change the parity enable.
- R8: If parity and ID errors occur on the same bit, the checker sets both status bits.
- R9: Once any status bit is set, `init_n` stays 0 and `err_status` stays unchanged, whatever bits arrive, until reset or program.
- R10: `prog` clears the checker on the next edge. A bit offered in the same cycle as `prog` is dropped.
- R11: `init_n` and `err_status` change on the clock edge that accepts the offending bit, and not earlier.
- R12: `in_ready` is always 1, so the checker never back-pressures the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog | input | 1 | Synchronous program request, clears all state |
| in_valid | input | 1 | A stream bit is offered |
| in_ready | output | 1 | Always 1 |
| in_data | input | 1 | Stream bit |
| init_n | output | 1 | Low while an error is latched |
| err_status | output | 3 | Sticky flags: [0] alignment, [1] parity, [2] ID code |

## Verification
The parity check and the ID comparison both resolve on the last bit of an ID frame. The bench provokes this collision by enabling parity with one correct ID frame and then sending an ID frame with a wrong code and a corrupted even group. It expects both flags set after that single edge. A separate case makes the ID frame that turns parity on carry bad parity itself, and expects no error, which shows the old enable governs that frame. Random frames mix both kinds of frame with random parity damage and short stop runs, and a bench model scores each one.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;
  localparam int ERR_W     = 3;
  localparam int ERR_ALIGN = 0;
  localparam int ERR_PAR   = 1;
  localparam int ERR_ID    = 2;
  typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/cfgchk_framer.sv
module cfgchk_framer #(
  parameter int FRAME_LEN = 24,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             bit_in,
  output logic             start_hit,
  output logic             last_hit,
  output logic             in_frame,
  output logic [POS_W-1:0] pos_cur
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic             busy_q;
  logic [POS_W-1:0] pos_q;

  assign start_hit = take & ~busy_q & ~bit_in;
  assign last_hit  = take & busy_q & (pos_q == LAST);
  assign in_frame  = busy_q;
  assign pos_cur   = busy_q ? pos_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (start_hit) begin
      busy_q <= 1'b1;
      pos_q  <= POS_W'(1);
    end else if (last_hit) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (take && busy_q) begin
      pos_q  <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/cfgchk_align.sv
module cfgchk_align #(
  parameter int GUARD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic bit_in,
  input  logic start_hit,
  output logic misalign
);
  logic [GUARD-1:0] hist_q;

  assign misalign = start_hit & ~(&hist_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist_q <= '0;
    else if (clr)   hist_q <= '0;
    else if (take)  hist_q <= {hist_q[GUARD-2:0], bit_in};
  end
endmodule

// File: rtl/cfgchk_parity.sv
module cfgchk_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic in_frame,
  input  logic start_hit,
  input  logic pos_lsb,
  input  logic bit_in,
  output logic odd_seen
);
  logic [1:0] fin;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic acc_q;
    logic hit;
    assign hit    = take & in_frame & bit_in & (pos_lsb == g[0]);
    assign fin[g] = acc_q ^ hit;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc_q <= 1'b0;
      else if (clr)        acc_q <= 1'b0;
      else if (start_hit)  acc_q <= 1'b0;
      else if (hit)        acc_q <= ~acc_q;
    end
  end

  assign odd_seen = |fin;
endmodule

// File: rtl/cfgchk_idframe.sv
module cfgchk_idframe #(
  parameter int ID_ADDR_W = 4,
  parameter int CODE_W    = 8,
  parameter int POS_W     = 5,
  parameter logic [ID_ADDR_W-1:0] ID_ADDR  = '0,
  parameter logic [CODE_W-1:0]    DEV_CODE = '0,
  localparam int FIELD_W = ID_ADDR_W + CODE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             in_frame,
  input  logic [POS_W-1:0] pos_cur,
  input  logic             last_hit,
  input  logic             bit_in,
  output logic             code_bad,
  output logic             par_en
);
  localparam logic [POS_W-1:0] FLD_LO = POS_W'(1);
  localparam logic [POS_W-1:0] FLD_HI = POS_W'(FIELD_W);

  logic [FIELD_W-1:0]   fld_q;
  logic                 par_en_q;
  logic                 in_field;
  logic                 is_id;
  logic [ID_ADDR_W-1:0] got_addr;
  logic [CODE_W-1:0]    got_code;

  assign in_field = take & in_frame & (pos_cur >= FLD_LO) & (pos_cur <= FLD_HI);
  assign got_addr = fld_q[FIELD_W-1 -: ID_ADDR_W];
  assign got_code = fld_q[CODE_W:1];
  assign is_id    = (got_addr == ID_ADDR);
  assign code_bad = last_hit & is_id & (got_code != DEV_CODE);
  assign par_en   = par_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q    <= '0;
      par_en_q <= 1'b0;
    end else if (clr) begin
      fld_q    <= '0;
      par_en_q <= 1'b0;
    end else begin
      if (in_field)          fld_q    <= {fld_q[FIELD_W-2:0], bit_in};
      if (last_hit && is_id) par_en_q <= fld_q[0];
    end
  end
endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
  import cfgchk_pkg::*;
#(
  parameter int FRAME_LEN = 24,
  parameter int STOP_MIN  = 3,
  parameter int ID_ADDR_W = 4,
  parameter int CODE_W    = 8,
  parameter logic [ID_ADDR_W-1:0] ID_ADDR  = 4'hA,
  parameter logic [CODE_W-1:0]    DEV_CODE = 8'h5C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_data,
  output logic       init_n,
  output logic [2:0] err_status
);
  localparam int POS_W = $clog2(FRAME_LEN);

  logic             halted_q;
  err_vec_t         err_q;
  err_vec_t         hit;
  logic             take;
  logic             start_hit, last_hit, in_frame;
  logic [POS_W-1:0] pos_cur;
  logic             misalign, odd_seen, code_bad, par_en;

  assign in_ready = 1'b1;
  assign take     = in_valid & ~halted_q & ~prog;

  cfgchk_framer #(.FRAME_LEN(FRAME_LEN)) u_framer (
    .clk(clk), .rst_n(rst_n), .clr(prog), .take(take), .bit_in(in_data),
    .start_hit(start_hit), .last_hit(last_hit), .in_frame(in_frame),
    .pos_cur(pos_cur)
  );

  cfgchk_align #(.GUARD(STOP_MIN)) u_align (
    .clk(clk), .rst_n(rst_n), .clr(prog), .take(take), .bit_in(in_data),
    .start_hit(start_hit), .misalign(misalign)
  );

  cfgchk_parity u_parity (
    .clk(clk), .rst_n(rst_n), .clr(prog), .take(take), .in_frame(in_frame),
    .start_hit(start_hit), .pos_lsb(pos_cur[0]), .bit_in(in_data),
    .odd_seen(odd_seen)
  );

  cfgchk_idframe #(
    .ID_ADDR_W(ID_ADDR_W), .CODE_W(CODE_W), .POS_W(POS_W),
    .ID_ADDR(ID_ADDR), .DEV_CODE(DEV_CODE)
  ) u_idframe (
    .clk(clk), .rst_n(rst_n), .clr(prog), .take(take), .in_frame(in_frame),
    .pos_cur(pos_cur), .last_hit(last_hit), .bit_in(in_data),
    .code_bad(code_bad), .par_en(par_en)
  );

  always_comb begin
    hit            = '0;
    hit[ERR_ALIGN] = misalign;
    hit[ERR_PAR]   = last_hit & par_en & odd_seen;
    hit[ERR_ID]    = code_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      err_q    <= '0;
    end else if (prog) begin
      halted_q <= 1'b0;
      err_q    <= '0;
    end else if (|hit) begin
      halted_q <= 1'b1;
      err_q    <= err_q | hit;
    end
  end

  assign init_n     = ~halted_q;
  assign err_status = err_q;
endmodule

// File: rtl/cfgchk_checker.sv
module cfgchk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       prog,
  input logic       in_ready,
  input logic       init_n,
  input logic [2:0] err_status
);
  a_r12_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n && !prog) |=> !init_n);

  a_r9_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n && !prog) |=> $stable(err_status));

  a_r10_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (init_n && err_status == 3'b000));

  a_r11_init_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    init_n == (err_status == 3'b000));
endmodule

bind cfg_frame_checker cfgchk_checker u_cfgchk_checker (
  .clk(clk), .rst_n(rst_n), .prog(prog), .in_ready(in_ready),
  .init_n(init_n), .err_status(err_status)
);

// File: tb/test_cfg_frame_checker.sv
`timescale 1ns/1ps
module test_cfg_frame_checker;
  localparam int FL = 24;
  localparam int AW = 4;
  localparam int CW = 8;
  localparam int F  = AW + CW + 1;
  localparam logic [AW-1:0] IDA = 4'hA;
  localparam logic [CW-1:0] DEV = 8'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog = 1'b0;
  logic in_valid = 1'b0;
  logic in_data = 1'b1;
  logic in_ready;
  logic init_n;
  logic [2:0] err_status;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [2:0]   m_hist;
  logic         m_busy;
  int           m_pos;
  logic         m_pe, m_po, m_pen, m_halt;
  logic [F-1:0] m_sh;
  logic [2:0]   m_stat;

  always #10 clk = ~clk;

  cfg_frame_checker i_cfg_frame_checker (
    .clk(clk), .rst_n(rst_n), .prog(prog), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .init_n(init_n),
    .err_status(err_status)
  );

  task automatic model_clear();
    m_hist = 3'b000; m_busy = 1'b0; m_pos = 0; m_pe = 1'b0; m_po = 1'b0;
    m_pen = 1'b0; m_halt = 1'b0; m_sh = '0; m_stat = 3'b000;
  endtask

  task automatic model_bit(input logic b);
    logic [2:0] nw;
    int p;
    nw = 3'b000;
    if (m_halt) return;
    if (!m_busy) begin
      if (!b) begin
        if (m_hist != 3'b111) nw[0] = 1'b1;
        m_busy = 1'b1; m_pos = 1; m_pe = 1'b0; m_po = 1'b0; m_sh = '0;
      end
    end else begin
      p = m_pos;
      if (p >= 1 && p <= F) m_sh = {m_sh[F-2:0], b};
      if (p % 2 == 0) m_pe = m_pe ^ b; else m_po = m_po ^ b;
      if (p == FL-1) begin
        m_busy = 1'b0;
        if (m_pen && (m_pe || m_po)) nw[1] = 1'b1;
        if (m_sh[F-1 -: AW] == IDA) begin
          if (m_sh[CW:1] != DEV) nw[2] = 1'b1;
          m_pen = m_sh[0];
        end
      end else m_pos = p + 1;
    end
    m_hist = {m_hist[1:0], b};
    m_stat = m_stat | nw;
    if (nw != 3'b000) m_halt = 1'b1;
  endtask

  task automatic check(input string tag, input logic exp_init, input logic [2:0] exp_stat);
    checks++;
    if (init_n !== exp_init || err_status !== exp_stat) begin
      fails++;
      $display("FAIL %s: init_n=%0b err_status=%b expected init_n=%0b err_status=%b",
               tag, init_n, err_status, exp_init, exp_stat);
    end
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1; in_data = b;
    @(posedge clk);
    model_bit(b);
    @(negedge clk);
  endtask

  task automatic send_stops(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [FL-1:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(v[i]);
    in_valid = 1'b0;
  endtask

  task automatic do_prog(input logic with_bit);
    prog = 1'b1; in_valid = with_bit; in_data = 1'b0;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    prog = 1'b0; in_valid = 1'b0;
  endtask

  // kind: 0 plain frame, 1 ID frame
  function automatic logic [FL-1:0] make_frame(input bit is_id, input logic [CW-1:0] code,
      input logic flag, input bit bad_even, input bit bad_odd);
    logic [FL-1:0] v;
    logic [F-1:0]  fld;
    logic [AW-1:0] a;
    logic pe, po;
    v = FL'($urandom);
    a = is_id ? IDA : AW'($urandom);
    if (!is_id && a == IDA) a = ~IDA;
    fld = {a, code, flag};
    v[0] = 1'b0;
    for (int k = 0; k < F; k++) v[1+k] = fld[F-1-k];
    pe = 1'b0; po = 1'b0;
    for (int k = 0; k < FL-2; k++) begin
      if (k % 2 == 0) pe = pe ^ v[k]; else po = po ^ v[k];
    end
    v[FL-2] = pe ^ bad_even;
    v[FL-1] = po ^ bad_odd;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [FL-1:0] fr;
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 1'b1, 3'b000);
    checks++;
    if (in_ready !== 1'b1) begin
      fails++; $display("FAIL R12: in_ready=%0b expected=1", in_ready);
    end

    // R2 good plain frame
    send_stops(4);
    send_frame(make_frame(0, 8'h00, 1'b1, 0, 0), FL);
    check("R2 plain frame accepted", 1'b1, 3'b000);
    // R5 bad parity ignored while disabled
    send_stops(3);
    send_frame(make_frame(0, 8'h00, 1'b0, 1, 0), FL);
    check("R5 parity off by default", 1'b1, 3'b000);
    // R5 enabling ID frame judged with old enable
    send_stops(3);
    send_frame(make_frame(1, DEV, 1'b1, 0, 1), FL);
    check("R5 enable applies from next frame", 1'b1, 3'b000);
    // R4 + R11 odd group error timing
    send_stops(3);
    fr = make_frame(0, 8'h00, 1'b0, 0, 1);
    send_frame(fr, FL-1);
    check("R11 no error before last bit", 1'b1, 3'b000);
    send_bit(fr[FL-1]); in_valid = 1'b0;
    check("R4 odd group parity error", 1'b0, 3'b010);
    // R9 ignored input
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    send_frame(make_frame(1, ~DEV, 1'b0, 1, 1), FL);
    check("R9 status frozen in error state", 1'b0, 3'b010);
    checks++;
    if (in_ready !== 1'b1) begin
      fails++; $display("FAIL R12: in_ready=%0b expected=1", in_ready);
    end
    // R10 prog with a zero offered
    do_prog(1'b1);
    check("R10 prog clears", 1'b1, 3'b000);
    send_stops(3);
    send_frame(make_frame(0, 8'h00, 1'b0, 1, 0), FL);
    check("R10 prog dropped bit and cleared enable", 1'b1, 3'b000);
    // R3 alignment: only two ones after clear
    do_prog(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); in_valid = 1'b0;
    check("R3 too few stop bits", 1'b0, 3'b001);
    // R3 stream opening with zero
    do_prog(1'b0);
    send_bit(1'b0); in_valid = 1'b0;
    check("R3 start bit right after clear", 1'b0, 3'b001);
    // R8 parity and ID on same bit
    do_prog(1'b0);
    send_stops(3);
    send_frame(make_frame(1, DEV, 1'b1, 0, 0), FL);
    check("R6 matching ID frame", 1'b1, 3'b000);
    send_stops(3);
    send_frame(make_frame(1, DEV ^ 8'h01, 1'b1, 1, 0), FL);
    check("R8 parity and ID together", 1'b0, 3'b110);
    // R6 ID mismatch alone
    do_prog(1'b0);
    send_stops(5);
    send_frame(make_frame(1, 8'h00, 1'b0, 0, 0), FL);
    check("R6 ID code mismatch", 1'b0, 3'b100);
    // R7 plain frame carrying garbage code, parity on
    do_prog(1'b0);
    send_stops(3);
    send_frame(make_frame(1, DEV, 1'b1, 0, 0), FL);
    send_stops(3);
    send_frame(make_frame(0, 8'hFF, 1'b0, 0, 0), FL);
    send_stops(3);
    send_frame(make_frame(0, 8'h00, 1'b0, 1, 0), FL);
    check("R7 plain frame kept parity enabled", 1'b0, 3'b010);
    // R5 ID frame with flag 0 turns parity off
    do_prog(1'b0);
    send_stops(3);
    send_frame(make_frame(1, DEV, 1'b1, 0, 0), FL);
    send_stops(3);
    send_frame(make_frame(1, DEV, 1'b0, 0, 0), FL);
    send_stops(10);
    send_frame(make_frame(0, 8'h00, 1'b0, 0, 1), FL);
    check("R5 flag 0 disables parity", 1'b1, 3'b000);

    // random phase against bench model
    do_prog(1'b0);
    for (int it = 0; it < 200; it++) begin
      int kind;
      if (m_halt) do_prog(1'($urandom % 2));
      send_stops(int'($urandom % 5) + 1);
      kind = int'($urandom % 4);
      fr = make_frame(kind >= 2, (kind == 3) ? DEV ^ CW'($urandom % 2) : DEV,
                      1'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0);
      send_frame(fr, FL);
      check("R2/R3/R4/R6 random frame", ~m_halt, m_stat);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule